// File: doc/BRIEF.md
# Status-Poll Completion Checker

This block runs on the host side of a parallel flash. After the host has written a program or erase command, the block polls the device's status word through a simple read port and decides whether the operation passed or failed. Bit 7 of each status word is the completion bit. During an operation it reads as the complement of the expected value, and it reads true once the operation ends. Bit 5 is the device's timeout flag.

To use it, the host pulses `start_i` with a valid polling address and the operation type. For a program, the address is the programmed location. For an erase, it is any address in a sector being erased. The checker keeps issuing reads until it can decide. Once bit 7 shows the true value, it reads once more, because the remaining bits may still be settling on the read that first matched. If the timeout flag appears, it makes exactly one more read before it declares a failure, because the two bits can change together. A poll limit set by a parameter ends the run as a failure if the device never answers.

Top module: `dpoll_checker`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start, `busy_o`, `done_o`, `pass_o` and `rd_req_o` are 0 and `final_data_o` is 0.
- R2: A `start_i` pulse while idle captures `addr_i` and the operation type and sets `busy_o`. Every read is presented with `rd_addr_o` equal to the captured address. `rd_req_o` stays high until a cycle where `rd_ack_i` is high, and that cycle completes the read with `rd_data_i`.
- R3: The expected value of bit 7 is 1 when `erase_i` is 1. When `erase_i` is 0 it is `prog_bit_i`.
- R4: A read whose bit 7 equals the expected value is followed by exactly one more read. That second word becomes `final_data_o`, and the run ends with `pass_o`=1.
- R5: A read whose bit 7 mismatches and whose bit 5 is 0 causes another polling read.
- R6: A read whose bit 7 mismatches and whose bit 5 is 1 causes one recheck read. If the recheck matches on bit 7, the flow of R4 follows. If it mismatches, the run ends with `pass_o`=0 and that word in `final_data_o`.
- R7: A word that matches on bit 7 and also has bit 5 set is treated as a match.
- R8: After `MAX_POLLS` polling reads that mismatch with bit 5 clear, the run ends with `pass_o`=0 and the last word in `final_data_o`. If the read that reaches the limit has bit 5 set, the recheck of R6 takes place instead.
- R9: `done_o`, `pass_o` and `final_data_o` hold their values until the next start, and `rd_req_o` is low while `done_o` is high. `done_o` is 0 in the cycle after a start is accepted.
- R10: `start_i` is ignored while `busy_o` is high. The captured address and operation stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| erase_i | input | 1 | 1 = erase operation, 0 = program |
| prog_bit_i | input | 1 | Bit 7 of the programmed datum |
| addr_i | input | ADDR_W | Valid polling address |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read complete, data valid |
| rd_data_i | input | DATA_W | Status/data word |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Result available |
| pass_o | output | 1 | 1 = operation passed |
| final_data_o | output | DATA_W | Word from the final read |

## Verification
Two decisions can fall on the same read. One word can carry a bit 7 match together with the timeout flag. The read that reaches the poll limit can also carry the timeout flag. The bench provokes both. It returns 0xA0 during an erase, and it places a bit-5 word at exactly the limit-th polling read. It then judges the outcome by the count of reads issued and by the final word and verdict: the match must win in the first case, and the recheck must win in the second.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_POLL,
    PH_RECHECK,
    PH_CONFIRM
  } phase_e;

  function automatic logic expected_bit(input logic erase, input logic prog_bit);
    return erase ? 1'b1 : prog_bit;
  endfunction
endpackage

// File: rtl/dpoll_classify.sv
module dpoll_classify (
  input  logic exp_bit_i,
  input  logic stat_bit_i,
  input  logic tmo_bit_i,
  output logic match_o,
  output logic tmo_o
);
  assign match_o = (stat_bit_i == exp_bit_i);
  assign tmo_o   = tmo_bit_i;
endmodule

// File: rtl/dpoll_limit.sv
module dpoll_limit #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (inc_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_hit_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !clr_i |=> cnt_q == LAST);
endmodule

// File: rtl/dpoll_result.sv
module dpoll_result #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fin_i,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (fin_i) begin
      done_o <= 1'b1;
      pass_o <= pass_i;
      data_o <= data_i;
    end
  end

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o && $stable(pass_o) && $stable(data_o));
endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
  import dpoll_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int STAT_BIT  = 7,
  parameter int TMO_BIT   = 5,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic              prog_bit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [DATA_W-1:0] final_data_o
);
  phase_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic exp_q;
  logic match, tmo, hit;
  logic rd_fire, launch, poll_miss, finish, fin_pass;

  assign busy_o    = (state_q != PH_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = addr_q;
  assign rd_fire   = rd_req_o & rd_ack_i;
  assign launch    = (state_q == PH_IDLE) & start_i;
  // plain miss: counts toward the poll limit
  assign poll_miss = rd_fire && (state_q == PH_POLL) && !match && !tmo;

  dpoll_classify u_classify (
    .exp_bit_i (exp_q),
    .stat_bit_i(rd_data_i[STAT_BIT]),
    .tmo_bit_i (rd_data_i[TMO_BIT]),
    .match_o   (match),
    .tmo_o     (tmo)
  );

  dpoll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .inc_i (poll_miss),
    .hit_o (hit)
  );

  dpoll_result #(.DATA_W(DATA_W)) u_result (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .fin_i (finish),
    .pass_i(fin_pass),
    .data_i(rd_data_i),
    .done_o(done_o),
    .pass_o(pass_o),
    .data_o(final_data_o)
  );

  always_comb begin
    state_d  = state_q;
    finish   = 1'b0;
    fin_pass = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) state_d = PH_POLL;
      PH_POLL: if (rd_fire) begin
        if (match)    state_d = PH_CONFIRM;
        else if (tmo) state_d = PH_RECHECK;
        else if (hit) begin
          finish  = 1'b1;
          state_d = PH_IDLE;
        end
      end
      PH_RECHECK: if (rd_fire) begin
        if (match) state_d = PH_CONFIRM;
        else begin
          finish  = 1'b1;
          state_d = PH_IDLE;
        end
      end
      PH_CONFIRM: if (rd_fire) begin
        finish   = 1'b1;
        fin_pass = 1'b1;
        state_d  = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      addr_q  <= '0;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        addr_q <= addr_i;
        exp_q  <= expected_bit(erase_i, prog_bit_i);
      end
    end
  end

  assert_done_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_req_o && rd_ack_i));
  assert_pass_from_confirm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && pass_o |-> $past(state_q == PH_CONFIRM));
  assert_no_req_when_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !rd_ack_i |=> busy_o && $stable(rd_addr_o));
endmodule

// File: tb/dpoll_checker_test.sv
module dpoll_checker_test;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int MAXP = 8;

  typedef struct packed {
    logic       erase;
    logic       pbit;
    logic [7:0] w0, w1, w2, w3;
    logic       exp_pass;
    logic [7:0] exp_data;
    logic [7:0] exp_reads;
  } vec_t;

  // R3/R4/R5/R6/R7 vectors
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 8'h80, 8'hFF, 8'hFF, 8'hFF, 1'b1, 8'hFF, 8'd2},
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h80, 8'h3C, 1'b1, 8'h3C, 8'd4},
    '{1'b1, 1'b0, 8'h20, 8'h20, 8'h20, 8'h20, 1'b0, 8'h20, 8'd2},
    '{1'b1, 1'b0, 8'h20, 8'hA0, 8'hFF, 8'hFF, 1'b1, 8'hFF, 8'd3},
    '{1'b1, 1'b0, 8'hA0, 8'h55, 8'h55, 8'h55, 1'b1, 8'h55, 8'd2},
    '{1'b0, 1'b0, 8'h80, 8'h00, 8'h5A, 8'h5A, 1'b1, 8'h5A, 8'd3},
    '{1'b0, 1'b1, 8'h00, 8'h80, 8'hC3, 8'hC3, 1'b1, 8'hC3, 8'd3},
    '{1'b0, 1'b0, 8'hA0, 8'hA5, 8'hA5, 8'hA5, 1'b0, 8'hA5, 8'd2},
    '{1'b0, 1'b1, 8'h7F, 8'hFF, 8'hE7, 8'hE7, 1'b1, 8'hE7, 8'd3},
    '{1'b0, 1'b1, 8'h1F, 8'h80, 8'h01, 8'h01, 1'b1, 8'h01, 8'd3}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, erase_i = 1'b0, prog_bit_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic busy_o, done_o, pass_o;
  logic [DW-1:0] final_data_o;

  int n_chk = 0, n_bad = 0;
  int rd_idx = 0, pre_n = 0, stall = 0, addr_err = 0;
  logic [7:0] pre_w = 8'h00;
  logic [7:0] seq [4];
  logic [AW-1:0] cur_addr = '0;

  always #5 clk_i = ~clk_i;

  dpoll_checker #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) uut (
    .clk_i, .rst_ni, .start_i, .erase_i, .prog_bit_i, .addr_i,
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .busy_o, .done_o, .pass_o, .final_data_o
  );

  function automatic logic [7:0] pick(int i);
    int j;
    if (i < pre_n) return pre_w;
    j = i - pre_n;
    if (j > 3) j = 3;
    return seq[j];
  endfunction

  // flash model: answers each request, optional stall cycles
  always @(negedge clk_i) begin
    if (rd_req_o && stall > 0) begin
      stall <= stall - 1;
      rd_ack_i <= 1'b0;
    end else if (rd_req_o) begin
      rd_ack_i  <= 1'b1;
      rd_data_i <= pick(rd_idx);
      if (rd_addr_o != cur_addr) addr_err <= addr_err + 1;
      rd_idx <= rd_idx + 1;
    end else begin
      rd_ack_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done_o && w < 300) begin
      @(negedge clk_i);
      w++;
    end
  endtask

  task automatic run_case(input logic er, input logic pb, input logic [AW-1:0] a,
                          input logic ep, input logic [7:0] ed, input int er_n,
                          input string req);
    rd_idx = 0; addr_err = 0; cur_addr = a;
    erase_i = er; prog_bit_i = pb; addr_i = a; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && busy_o, "R9", "done cleared/busy after start", {done_o, busy_o}, 2'b01);
    wait_done();
    chk(done_o, req, "done", done_o, 1);
    chk(pass_o == ep, req, "pass", pass_o, ep);
    chk(final_data_o == ed, req, "final_data", final_data_o, ed);
    chk(rd_idx == er_n, req, "read count", rd_idx, er_n);
    chk(addr_err == 0, "R2", "read address", addr_err, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic hp;
    logic [7:0] hd;
    seq = '{8'h00, 8'h00, 8'h00, 8'h00};
    repeat (2) @(negedge clk_i);
    chk({busy_o, done_o, pass_o, rd_req_o} == 4'b0 && final_data_o == 0, "R1",
        "outputs in reset", {busy_o, done_o, pass_o, rd_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({busy_o, done_o, rd_req_o} == 3'b0, "R1", "idle after reset",
        {busy_o, done_o, rd_req_o}, 0);

    foreach (VECS[i]) begin
      seq = '{VECS[i].w0, VECS[i].w1, VECS[i].w2, VECS[i].w3};
      pre_n = 0;
      run_case(VECS[i].erase, VECS[i].pbit, AW'(32'h1000 + i * 7),
               VECS[i].exp_pass, VECS[i].exp_data, int'(VECS[i].exp_reads), "R4/R5/R6");
      @(negedge clk_i);
    end

    // R9: hold after completion
    hp = pass_o; hd = final_data_o;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk(done_o && pass_o == hp && final_data_o == hd && !rd_req_o, "R9",
          "result held", {done_o, pass_o, final_data_o}, {1'b1, hp, hd});
    end

    // R8: limit reached with plain misses
    pre_n = 0; seq = '{8'h00, 8'h00, 8'h00, 8'h00};
    run_case(1'b1, 1'b0, 20'h0ABCD, 1'b0, 8'h00, MAXP, "R8");
    // R8: one short of limit then match
    pre_n = MAXP - 1; pre_w = 8'h00; seq = '{8'h80, 8'h99, 8'h99, 8'h99};
    run_case(1'b1, 1'b0, 20'h0ABCE, 1'b1, 8'h99, MAXP + 1, "R8");
    // R8/R6: timeout flag on limit-reaching read forces recheck
    seq = '{8'h20, 8'h20, 8'h20, 8'h20};
    run_case(1'b1, 1'b0, 20'h0ABCF, 1'b0, 8'h20, MAXP + 1, "R8");
    pre_n = 0;

    // R10: start while busy ignored
    seq = '{8'h00, 8'h11, 8'h11, 8'h11};
    rd_idx = 0; addr_err = 0; cur_addr = 20'h05555; stall = 4;
    erase_i = 1'b0; prog_bit_i = 1'b0; addr_i = 20'h05555; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    erase_i = 1'b1; prog_bit_i = 1'b1; addr_i = 20'h0AAAA; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    chk(done_o && pass_o, "R10", "pass with original op", {done_o, pass_o}, 2'b11);
    chk(final_data_o == 8'h11, "R10", "final_data", final_data_o, 8'h11);
    chk(rd_idx == 2, "R10", "read count", rd_idx, 2);
    chk(addr_err == 0, "R10", "address unchanged", addr_err, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule